// File: doc/BRIEF.md
# Two-Wire Bus Write Receiver

This block is a slave-only receiver for a two-wire serial bus (I2C-style). It is clocked by a fast system clock. The SCL and SDA line levels are brought into that clock domain through a two-stage synchroniser, and every bus event is derived from the synchronised copies.

The block detects START, repeated START and STOP conditions. It shifts in 8-bit words and compares the first word of each frame against a 7-bit device address. The upper six bits of that address are a parameter, and the lowest bit follows an external select pin. When the address matches and the direction bit requests a write, the block acknowledges by pulling SDA low through an open-drain enable. It then hands every following byte to a register bank as a one-cycle strobe with a running byte index.

A frame-end pulse tells the register bank when a STOP or repeated START closes a frame it accepted. After a STOP or a non-matching address, the block ignores all clock activity until the next START. Read transfers and clock stretching are not provided. The system clock must run at least 8 times faster than the bus clock.

Top module: `twr_wr_rx`

## Requirements
- R1: After reset, with both bus lines idle high, `sda_oe`, `byte_vld` and `frame_end` are all 0.
- R2: After a START (SDA falling while SCL is high), the next 8 bits are sampled MSB first on SCL rising edges. The address matches when the first 7 bits equal {ADDR_HI[5:0], addr_sel} and the eighth bit (direction) is 0.
- R3: For a matching address and for every data byte after it, `sda_oe` goes to 1 on the SCL falling edge after the eighth bit. It returns to 0 on the SCL falling edge that ends the ninth (acknowledge) clock pulse.
- R4: If the address does not match, or the direction bit is 1, no acknowledge is given. All further clocks and data are then ignored (no acknowledge, no byte strobe) until the next START.
- R5: Each data byte after the address produces a one-cycle `byte_vld` pulse with `byte_data` (first bit received is bit 7). `byte_idx` is 0 for the first byte after the address and increases by 1 for each later byte in the frame.
- R6: A STOP (SDA rising while SCL is high) at any bit position ends the frame. Any partial byte is dropped, and the bus is ignored until the next START.
- R7: A repeated START ends an accepted frame with a `frame_end` pulse and begins a new address phase. In the new frame, `byte_idx` restarts at 0.
- R8: A STOP that falls in the same SCL high period as a START is not honoured. Address reception continues and no `frame_end` is produced.
- R9: `frame_end` pulses for one cycle on the STOP or repeated START that closes a frame whose address matched, and never for a frame that was not matched.
- R10: `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_sel | input | 1 | Supplies the lowest device address bit |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved bus value) |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| byte_vld | output | 1 | One-cycle strobe for a received write byte |
| byte_data | output | 8 | Received byte, valid with `byte_vld` |
| byte_idx | output | IDX_W | Position of the byte in the frame after the address |
| frame_end | output | 1 | One-cycle pulse when an accepted frame closes |

## Verification
Some rules hold on every cycle, and the bound checker tests those: the acknowledge enable moves only while the synchronised clock is low, and it is raised only right after a clock fall. A byte strobe always follows a clock rise, and a frame-end pulse always follows a START or an honoured STOP. No acknowledge is driven while the receiver is ignoring the bus, and a byte strobe never coincides with a frame-end pulse. Other behaviour depends on whole bus sequences, so only the directed scenarios can show it. These include address matching under both select levels, rejection of read requests, byte values and index order, the dropped partial byte after an early STOP, index restart after a repeated START, and a STOP ignored when it shares a high pulse with a START.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_ACK  = 2'd3
  } twr_state_e;
endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= '1;
          else        stg_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= '1;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= stg_q[STAGES-1];
  end

  assign q_o      = stg_q[STAGES-1];
  assign q_prev_o = prev_q;
endmodule

// File: rtl/twr_cond.sv
module twr_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic scl_p,
  input  logic sda_s,
  input  logic sda_p,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_ok
);
  logic scl_hi_both;
  logic stop_raw;
  logic start_in_high_q;
  logic start_in_high_d;
  logic flag_en;

  assign scl_hi_both = scl_s & scl_p;
  assign scl_rise    = scl_s & ~scl_p;
  assign scl_fall    = ~scl_s & scl_p;
  assign start_det   = scl_hi_both & sda_p & ~sda_s;
  assign stop_raw    = scl_hi_both & ~sda_p & sda_s;
  // a STOP sharing the high pulse with a START is not legal
  assign stop_ok     = stop_raw & ~start_in_high_q;

  assign flag_en = start_det | scl_fall;

  always_comb begin
    start_in_high_d = start_in_high_q;
    if (start_det)     start_in_high_d = 1'b1;
    else if (scl_fall) start_in_high_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       start_in_high_q <= 1'b0;
    else if (flag_en) start_in_high_q <= start_in_high_d;
  end
endmodule

// File: rtl/twr_fsm.sv
module twr_fsm
  import twr_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b011101,
  parameter int         IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_sel,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_ok,
  output logic               sda_oe,
  output logic               byte_vld,
  output logic [BYTE_W-1:0]  byte_data,
  output logic [IDX_W-1:0]   byte_idx,
  output logic               frame_end,
  output twr_state_e         state_o
);
  twr_state_e           st_q, st_d;
  logic [BIT_CNT_W-1:0] cnt_q, cnt_d;
  logic [BYTE_W-1:0]    sh_q, sh_d;
  logic                 ack_on_q, ack_on_d;
  logic                 match_q, match_d;
  logic                 oe_q, oe_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic                 vld_q, vld_d;
  logic [BYTE_W-1:0]    dat_q, dat_d;
  logic [IDX_W-1:0]     oidx_q, oidx_d;
  logic                 end_q, end_d;
  logic [BYTE_W-1:0]    shifted;
  logic                 last_bit;
  logic                 dat_en;

  assign shifted  = {sh_q[BYTE_W-2:0], sda_s};
  assign last_bit = (cnt_q == BIT_CNT_W'(BYTE_W - 1));

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    ack_on_d = ack_on_q;
    match_d  = match_q;
    oe_d     = oe_q;
    idx_d    = idx_q;
    vld_d    = 1'b0;
    dat_d    = dat_q;
    oidx_d   = oidx_q;
    end_d    = 1'b0;
    if (start_det) begin
      st_d     = ST_ADDR;
      cnt_d    = '0;
      ack_on_d = 1'b0;
      oe_d     = 1'b0;
      idx_d    = '0;
      end_d    = match_q;
      match_d  = 1'b0;
    end else if (stop_ok) begin
      st_d     = ST_IDLE;
      ack_on_d = 1'b0;
      oe_d     = 1'b0;
      end_d    = match_q;
      match_d  = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = shifted;
            cnt_d = cnt_q + 1'b1;
            if (last_bit) begin
              if (shifted == {ADDR_HI, addr_sel, 1'b0}) begin
                st_d    = ST_ACK;
                match_d = 1'b1;
              end else begin
                st_d = ST_IDLE;
              end
            end
          end
        end
        ST_DATA: begin
          if (scl_rise) begin
            sh_d  = shifted;
            cnt_d = cnt_q + 1'b1;
            if (last_bit) begin
              st_d   = ST_ACK;
              vld_d  = 1'b1;
              dat_d  = shifted;
              oidx_d = idx_q;
              idx_d  = idx_q + 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!ack_on_q) begin
              ack_on_d = 1'b1;
              oe_d     = 1'b1;
            end else begin
              ack_on_d = 1'b0;
              oe_d     = 1'b0;
              st_d     = ST_DATA;
              cnt_d    = '0;
            end
          end
        end
        default: begin
          st_d = ST_IDLE;
        end
      endcase
    end
  end

  assign dat_en = vld_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      ack_on_q <= 1'b0;
      match_q  <= 1'b0;
      oe_q     <= 1'b0;
      idx_q    <= '0;
      vld_q    <= 1'b0;
      end_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      ack_on_q <= ack_on_d;
      match_q  <= match_d;
      oe_q     <= oe_d;
      idx_q    <= idx_d;
      vld_q    <= vld_d;
      end_q    <= end_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q  <= '0;
      oidx_q <= '0;
    end else if (dat_en) begin
      dat_q  <= dat_d;
      oidx_q <= oidx_d;
    end
  end

  assign sda_oe    = oe_q;
  assign byte_vld  = vld_q;
  assign byte_data = dat_q;
  assign byte_idx  = oidx_q;
  assign frame_end = end_q;
  assign state_o   = st_q;
endmodule

// File: rtl/twr_wr_rx.sv
module twr_wr_rx
  import twr_pkg::*;
#(
  parameter logic [5:0] ADDR_HI     = 6'b011101,
  parameter int         IDX_W       = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_sel,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic             byte_vld,
  output logic [7:0]       byte_data,
  output logic [IDX_W-1:0] byte_idx,
  output logic             frame_end
);
  logic [1:0] rst_sync_q;
  logic       rst_sn;
  logic [1:0] line_s, line_p;
  logic       scl_s, scl_p, sda_s, sda_p;
  logic       scl_rise, scl_fall, start_det, stop_ok;
  twr_state_e fsm_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  twr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sn),
    .d_i      ({scl_i, sda_i}),
    .q_o      (line_s),
    .q_prev_o (line_p)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];
  assign scl_p = line_p[1];
  assign sda_p = line_p[0];

  twr_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_sn),
    .scl_s     (scl_s),
    .scl_p     (scl_p),
    .sda_s     (sda_s),
    .sda_p     (sda_p),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_ok   (stop_ok)
  );

  twr_fsm #(.ADDR_HI(ADDR_HI), .IDX_W(IDX_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sn),
    .addr_sel  (addr_sel),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_ok   (stop_ok),
    .sda_oe    (sda_oe),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .byte_idx  (byte_idx),
    .frame_end (frame_end),
    .state_o   (fsm_state)
  );
endmodule

// File: rtl/twr_wr_rx_chk.sv
module twr_wr_rx_chk
  import twr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_rise,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_ok,
  input logic       sda_oe,
  input logic       byte_vld,
  input logic       frame_end,
  input twr_state_e fsm_state
);
  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_s); // R10
  AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall)); // R3
  AST_BYTE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(scl_rise)); // R5
  AST_END_AFTER_COND: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> $past(start_det || stop_ok)); // R9
  AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_IDLE) |-> !sda_oe); // R4
  AST_BYTE_NOT_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld && frame_end)); // R6
endmodule

bind twr_wr_rx twr_wr_rx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .scl_rise  (scl_rise),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_ok   (stop_ok),
  .sda_oe    (sda_oe),
  .byte_vld  (byte_vld),
  .frame_end (frame_end),
  .fsm_state (fsm_state)
);

// File: tb/twr_wr_rx_tb.sv
`timescale 1ns/1ps
module twr_wr_rx_tb;
  localparam logic [5:0] AHI = 6'b011101;
  localparam int IDX_W = 4;
  localparam int HALF = 10;

  logic clk;
  logic rst_n;
  logic addr_sel;
  logic scl_m;
  logic sda_m;
  logic sda_bus;
  logic sda_oe;
  logic byte_vld;
  logic [7:0] byte_data;
  logic [IDX_W-1:0] byte_idx;
  logic frame_end;

  int n_chk;
  int n_bad;
  int n_bytes;
  int n_ends;
  logic [7:0] last_data;
  logic [IDX_W-1:0] last_idx;

  assign sda_bus = sda_m & ~sda_oe;

  twr_wr_rx #(.ADDR_HI(AHI), .IDX_W(IDX_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_sel  (addr_sel),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .sda_oe    (sda_oe),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .byte_idx  (byte_idx),
    .frame_end (frame_end)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && byte_vld) begin
      n_bytes   <= n_bytes + 1;
      last_data <= byte_data;
      last_idx  <= byte_idx;
    end
    if (rst_n && frame_end) n_ends <= n_ends + 1;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; t_wait();
    scl_m = 1'b1; t_wait();
    sda_m = 1'b0; t_wait();
    scl_m = 1'b0; t_wait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; t_wait();
    scl_m = 1'b1; t_wait();
    sda_m = 1'b1; t_wait();
  endtask

  task automatic bus_bit(input logic b);
    sda_m = b;    t_wait();
    scl_m = 1'b1; t_wait();
    scl_m = 1'b0; t_wait();
  endtask

  // sends 8 bits then the ack clock; ack = data line low during ack high
  task automatic bus_byte(input logic [7:0] v, output logic ack, output logic oe_after);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    sda_m = 1'b1; t_wait();
    scl_m = 1'b1; t_wait();
    ack = ~sda_bus;
    scl_m = 1'b0; t_wait();
    oe_after = sda_oe;
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    chk(byte_vld == 1'b0, "R1 byte_vld", byte_vld, 0);
    chk(frame_end == 1'b0, "R1 frame_end", frame_end, 0);
  endtask

  task automatic t_basic_write();
    logic ack, oe_a;
    int b0, e0;
    addr_sel = 1'b0;
    b0 = n_bytes; e0 = n_ends;
    bus_start();
    bus_byte({AHI, 1'b0, 1'b0}, ack, oe_a);
    chk(ack == 1'b1, "R2 address ack", ack, 1);
    chk(oe_a == 1'b0, "R3 release after ack", oe_a, 0);
    bus_byte(8'hA5, ack, oe_a);
    chk(ack == 1'b1, "R3 data ack", ack, 1);
    chk(n_bytes == b0 + 1, "R5 byte count", n_bytes, b0 + 1);
    chk(last_data == 8'hA5, "R5 byte data", last_data, 8'hA5);
    chk(last_idx == 0, "R5 first idx", last_idx, 0);
    bus_byte(8'h3C, ack, oe_a);
    chk(last_data == 8'h3C, "R5 second data", last_data, 8'h3C);
    chk(last_idx == 1, "R5 second idx", last_idx, 1);
    chk(n_ends == e0, "R9 no end yet", n_ends, e0);
    bus_stop();
    t_wait();
    chk(n_ends == e0 + 1, "R9 end on stop", n_ends, e0 + 1);
    chk(sda_oe == 1'b0, "R6 idle oe", sda_oe, 0);
  endtask

  task automatic t_addr_sel();
    logic ack, oe_a;
    int e0;
    addr_sel = 1'b1;
    e0 = n_ends;
    bus_start();
    bus_byte({AHI, 1'b0, 1'b0}, ack, oe_a);
    chk(ack == 1'b0, "R4 lsb mismatch no ack", ack, 0);
    bus_stop(); t_wait();
    chk(n_ends == e0, "R9 no end for unmatched", n_ends, e0);
    bus_start();
    bus_byte({AHI, 1'b1, 1'b0}, ack, oe_a);
    chk(ack == 1'b1, "R2 lsb from addr_sel", ack, 1);
    bus_stop(); t_wait();
    chk(n_ends == e0 + 1, "R9 end matched", n_ends, e0 + 1);
    addr_sel = 1'b0;
  endtask

  task automatic t_read_bit();
    logic ack, oe_a;
    int b0;
    b0 = n_bytes;
    bus_start();
    bus_byte({AHI, 1'b0, 1'b1}, ack, oe_a);
    chk(ack == 1'b0, "R4 read bit no ack", ack, 0);
    bus_byte(8'h55, ack, oe_a);
    chk(ack == 1'b0, "R4 ignored byte no ack", ack, 0);
    chk(n_bytes == b0, "R4 ignored byte no strobe", n_bytes, b0);
    bus_stop(); t_wait();
  endtask

  task automatic t_early_stop();
    logic ack, oe_a;
    int b0, e0;
    b0 = n_bytes; e0 = n_ends;
    bus_start();
    bus_byte({AHI, 1'b0, 1'b0}, ack, oe_a);
    chk(ack == 1'b1, "R6 setup ack", ack, 1);
    for (int i = 0; i < 4; i++) bus_bit(1'b1);
    bus_stop(); t_wait();
    chk(n_ends == e0 + 1, "R6 end on early stop", n_ends, e0 + 1);
    chk(n_bytes == b0, "R6 partial byte dropped", n_bytes, b0);
    bus_byte(8'h81, ack, oe_a);
    chk(ack == 1'b0, "R6 ignored after stop", ack, 0);
    chk(n_bytes == b0, "R6 no strobe after stop", n_bytes, b0);
    bus_stop(); t_wait();
  endtask

  task automatic t_rep_start();
    logic ack, oe_a;
    int e0;
    e0 = n_ends;
    bus_start();
    bus_byte({AHI, 1'b0, 1'b0}, ack, oe_a);
    bus_byte(8'h11, ack, oe_a);
    bus_byte(8'h12, ack, oe_a);
    chk(last_idx == 1, "R7 idx before sr", last_idx, 1);
    bus_start();
    chk(n_ends == e0 + 1, "R7 end on repeated start", n_ends, e0 + 1);
    bus_byte({AHI, 1'b0, 1'b0}, ack, oe_a);
    chk(ack == 1'b1, "R7 address after sr", ack, 1);
    bus_byte(8'h22, ack, oe_a);
    chk(last_data == 8'h22, "R7 data after sr", last_data, 8'h22);
    chk(last_idx == 0, "R7 idx restarts", last_idx, 0);
    bus_stop(); t_wait();
    chk(n_ends == e0 + 2, "R9 end after sr frame", n_ends, e0 + 2);
  endtask

  task automatic t_illegal_stop();
    logic ack, oe_a;
    int e0, b0;
    e0 = n_ends; b0 = n_bytes;
    sda_m = 1'b1; scl_m = 1'b1; t_wait();
    sda_m = 1'b0; t_wait();
    sda_m = 1'b1; t_wait();
    scl_m = 1'b0; t_wait();
    chk(n_ends == e0, "R8 no end", n_ends, e0);
    bus_byte({AHI, 1'b0, 1'b0}, ack, oe_a);
    chk(ack == 1'b1, "R8 address still taken", ack, 1);
    bus_byte(8'hC3, ack, oe_a);
    chk(n_bytes == b0 + 1, "R8 byte received", n_bytes, b0 + 1);
    chk(last_data == 8'hC3, "R8 byte data", last_data, 8'hC3);
    bus_stop(); t_wait();
    chk(n_ends == e0 + 1, "R8 legal stop later", n_ends, e0 + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0; n_bytes = 0; n_ends = 0;
    last_data = '0; last_idx = '0;
    rst_n = 1'b0; addr_sel = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_basic_write();
    t_addr_sel();
    t_read_bit();
    t_early_stop();
    t_rep_start();
    t_illegal_stop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule